// File: doc/BRIEF.md
# Dual-Width Integer ALU

This block is a single-cycle integer arithmetic and logic unit on 64-bit operands. Each operation runs in either a narrow (32-bit) or a wide (64-bit) form, chosen by a width-select input on that cycle. In the narrow form, everything is computed on the low half of the operands. Shifts and rotates bring bits in at bit 31. The flags are taken from bit 31 and the low half of the result. The upper half of the result is always written as zero.

The second operand is one of three values: the register operand, the register operand's low 32 bits sign-extended (for a wide add or subtract), or a 12-bit unsigned immediate zero-extended to 64 bits. The result and the four condition flags are registered on the rising clock edge. The flags register is loaded only when the flag-update enable is high.

Top module: `dw_alu`

## Requirements
- R1: In wide mode, opcode 0 computes A+B and opcode 1 computes A-B over 64 bits. C is the carry out of bit 63; for subtract, C=1 means no borrow. V is signed overflow at bit 63.
- R2: In narrow mode (wide_i=0), add and subtract use only bits [31:0]. C and V are taken at bit 31, N is bit 31, and Z is set when bits [31:0] are all zero.
- R3: In narrow mode, result bits [63:32] are zero for every opcode, including the bitwise ones.
- R4: Opcodes 2, 3 and 4 are AND, OR and XOR. For these, and for the shift opcodes, C and V are written as 0. An unused opcode (9 to 15) gives a result of 0.
- R5: Opcodes 5, 6 and 7 are logical left shift, logical right shift and arithmetic right shift of A by shamt_i. The shift amount is taken modulo 64 in wide mode and modulo 32 in narrow mode. In narrow mode, the arithmetic shift fills from bit 31.
- R6: Opcode 8 rotates A right by shamt_i. The rotation is over 64 bits in wide mode and over bits [31:0] in narrow mode, with the amount taken modulo the active width.
- R7: When sext_b_i=1 on a wide add or subtract, B is replaced by its low 32 bits sign-extended to 64 bits before the operation.
- R8: When use_imm_i=1, B is replaced by imm_i zero-extended to 64 bits, and sext_b_i has no effect.
- R9: flags_o = {N,Z,C,V} (bit 3 down to bit 0) loads only on a cycle with flag_en_i=1. Otherwise it holds its value.
- R10: result_o shows the operation presented one rising edge earlier. A synchronous active-high reset clears result_o and flags_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code (see R1, R4, R5, R6) |
| wide_i | input | 1 | 1 = 64-bit form, 0 = 32-bit form |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second register operand |
| use_imm_i | input | 1 | Use the immediate as the second operand |
| imm_i | input | 12 | Unsigned immediate |
| sext_b_i | input | 1 | Sign-extend the low 32 bits of B for a wide add or subtract |
| shamt_i | input | 6 | Shift or rotate amount |
| flag_en_i | input | 1 | Flag register load enable |
| result_o | output | 64 | Registered result |
| flags_o | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The clocked properties assume that every input is driven to a known value on each cycle with reset low. The C/V-clear property assumes an opcode in the defined range 2 to 8, and the bench draws opcodes only from 0 to 8. Random stimulus uses the full 6-bit shift field in both widths, so amounts of 32 or more reach narrow-mode shifts and exercise the modulo rule. Random upper operand halves confirm that narrow operations ignore them. The directed cases target the carry and overflow boundaries, extension, and the override of the extend select by the immediate.

// File: rtl/dwalu_pkg.sv
package dwalu_pkg;

    localparam int DATA_W = 64;
    localparam int IMM_W  = 12;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_LSL = 4'd5,
        OP_LSR = 4'd6,
        OP_ASR = 4'd7,
        OP_ROR = 4'd8
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cc_t;

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic logic is_shift(alu_op_e op);
        return (op == OP_LSL) || (op == OP_LSR) || (op == OP_ASR) || (op == OP_ROR);
    endfunction

    function automatic shift_kind_e shift_kind(alu_op_e op);
        case (op)
            OP_LSR:  return SH_LSR;
            OP_ASR:  return SH_ASR;
            OP_ROR:  return SH_ROR;
            default: return SH_LSL;
        endcase
    endfunction

endpackage

// File: rtl/dwalu_opsel.sv
module dwalu_opsel #(
    parameter int DW  = 64,
    parameter int IMW = 12
) (
    input  logic          wide,
    input  logic          arith,
    input  logic          sext,
    input  logic          use_imm,
    input  logic [DW-1:0] reg_b,
    input  logic [IMW-1:0] imm,
    output logic [DW-1:0] b_eff
);
    localparam int HW = DW / 2;

    always_comb begin
        if (use_imm)
            b_eff = {{(DW-IMW){1'b0}}, imm};
        else if (wide && arith && sext)
            b_eff = {{HW{reg_b[HW-1]}}, reg_b[HW-1:0]};
        else
            b_eff = reg_b;
    end
endmodule

// File: rtl/dwalu_addsub.sv
module dwalu_addsub #(
    parameter int DW = 64
) (
    input  logic          wide,
    input  logic          sub,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] sum,
    output logic          carry,
    output logic          ovf
);
    localparam int HW = DW / 2;

    logic [DW-1:0] bx;
    logic [DW:0]   full_w;
    logic [HW:0]   full_n;

    always_comb begin
        bx     = sub ? ~b : b;
        full_w = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, sub};
        full_n = {1'b0, a[HW-1:0]} + {1'b0, bx[HW-1:0]} + {{HW{1'b0}}, sub};
        if (wide) begin
            sum   = full_w[DW-1:0];
            carry = full_w[DW];
            ovf   = (a[DW-1] == bx[DW-1]) && (full_w[DW-1] != a[DW-1]);
        end else begin
            sum   = {{HW{1'b0}}, full_n[HW-1:0]};
            carry = full_n[HW];
            ovf   = (a[HW-1] == bx[HW-1]) && (full_n[HW-1] != a[HW-1]);
        end
    end
endmodule

// File: rtl/dwalu_shift.sv
module dwalu_shift #(
    parameter int DW = 64
) (
    input  logic                    wide,
    input  dwalu_pkg::shift_kind_e  kind,
    input  logic [DW-1:0]           a,
    input  logic [$clog2(DW)-1:0]   amt,
    output logic [DW-1:0]           res
);
    import dwalu_pkg::*;
    localparam int HW = DW / 2;
    localparam int AW = $clog2(DW);

    logic [AW-1:0]   eff;
    logic [DW-1:0]   src;
    logic [DW-1:0]   sgn;
    logic [2*DW-1:0] rot_w;
    logic [DW-1:0]   rot_n;
    logic [DW-1:0]   raw;

    always_comb begin
        eff   = wide ? amt : {1'b0, amt[AW-2:0]};
        src   = wide ? a : {{HW{1'b0}}, a[HW-1:0]};
        sgn   = wide ? a : {{HW{a[HW-1]}}, a[HW-1:0]};
        rot_w = {a, a} >> eff;
        rot_n = {a[HW-1:0], a[HW-1:0]} >> eff;
        case (kind)
            SH_LSL:  raw = src << eff;
            SH_LSR:  raw = src >> eff;
            SH_ASR:  raw = $signed(sgn) >>> eff;
            default: raw = wide ? rot_w[DW-1:0] : {{HW{1'b0}}, rot_n[HW-1:0]};
        endcase
        res = wide ? raw : {{HW{1'b0}}, raw[HW-1:0]};
    end
endmodule

// File: rtl/dw_alu.sv
module dw_alu
    import dwalu_pkg::*;
#(
    parameter int DW  = dwalu_pkg::DATA_W,
    parameter int IMW = dwalu_pkg::IMM_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [3:0]            op_i,
    input  logic                  wide_i,
    input  logic [DW-1:0]         opa_i,
    input  logic [DW-1:0]         opb_i,
    input  logic                  use_imm_i,
    input  logic [IMW-1:0]        imm_i,
    input  logic                  sext_b_i,
    input  logic [$clog2(DW)-1:0] shamt_i,
    input  logic                  flag_en_i,
    output logic [DW-1:0]         result_o,
    output logic [3:0]            flags_o
);
    localparam int HW = DW / 2;

    alu_op_e       op;
    logic [DW-1:0] b_eff;
    logic [DW-1:0] sum;
    logic          carry, ovf;
    logic [DW-1:0] sh_res;
    logic [DW-1:0] res_d;
    cc_t           cc_d;
    cc_t           cc_q;
    logic [DW-1:0] res_q;

    assign op = alu_op_e'(op_i);

    dwalu_opsel #(.DW(DW), .IMW(IMW)) u_opsel (
        .wide(wide_i), .arith(is_arith(op)), .sext(sext_b_i),
        .use_imm(use_imm_i), .reg_b(opb_i), .imm(imm_i), .b_eff(b_eff)
    );

    // R8: an immediate never carries bits above its field
    p_imm_zext_r8: assert property (@(posedge clk) disable iff (rst)
        use_imm_i |-> (b_eff[DW-1:IMW] == '0));

    dwalu_addsub #(.DW(DW)) u_addsub (
        .wide(wide_i), .sub(op == OP_SUB), .a(opa_i), .b(b_eff),
        .sum(sum), .carry(carry), .ovf(ovf)
    );

    dwalu_shift #(.DW(DW)) u_shift (
        .wide(wide_i), .kind(shift_kind(op)), .a(opa_i),
        .amt(shamt_i), .res(sh_res)
    );

    always_comb begin
        case (op)
            OP_ADD, OP_SUB: res_d = sum;
            OP_AND: res_d = opa_i & b_eff;
            OP_OR:  res_d = opa_i | b_eff;
            OP_XOR: res_d = opa_i ^ b_eff;
            OP_LSL, OP_LSR, OP_ASR, OP_ROR: res_d = sh_res;
            default: res_d = '0;
        endcase
        if (!wide_i)
            res_d[DW-1:HW] = '0;
        cc_d.n = wide_i ? res_d[DW-1] : res_d[HW-1];
        cc_d.z = wide_i ? (res_d == '0) : (res_d[HW-1:0] == '0);
        cc_d.c = is_arith(op) ? carry : 1'b0;
        cc_d.v = is_arith(op) ? ovf : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            cc_q  <= '0;
        end else begin
            res_q <= res_d;
            if (flag_en_i)
                cc_q <= cc_d;
        end
    end

    assign result_o = res_q;
    assign flags_o  = cc_q;

    // R3: narrow form leaves the upper half clear
    p_upper_clear_r3: assert property (@(posedge clk) disable iff (rst)
        !wide_i |=> (result_o[DW-1:HW] == '0));

    // R2: Z agrees with the active part of the registered result
    p_zero_match_r2: assert property (@(posedge clk) disable iff (rst)
        flag_en_i |=> (flags_o[2] == ($past(wide_i) ? (result_o == '0)
                                                   : (result_o[HW-1:0] == '0))));

    // R4: non-arithmetic operations leave C and V clear
    p_logic_cv_r4: assert property (@(posedge clk) disable iff (rst)
        (flag_en_i && (op_i >= 4'd2) && (op_i <= 4'd8)) |=> (flags_o[1:0] == 2'b00));

    // R9: flags hold without the enable
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !flag_en_i |=> $stable(flags_o));

    // R10: reset clears both registers
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (result_o == '0 && flags_o == '0));

endmodule

// File: tb/sim_dw_alu.sv
`timescale 1ns/1ps
module sim_dw_alu;
    logic        clk = 0;
    logic        rst = 1;
    logic [3:0]  op_i = 0;
    logic        wide_i = 1;
    logic [63:0] opa_i = 0, opb_i = 0;
    logic        use_imm_i = 0;
    logic [11:0] imm_i = 0;
    logic        sext_b_i = 0;
    logic [5:0]  shamt_i = 0;
    logic        flag_en_i = 0;
    logic [63:0] result_o;
    logic [3:0]  flags_o;

    int checks = 0;
    int failures = 0;
    logic [3:0] exp_flags = 0;
    bit done = 0;

    dw_alu u0 (.*);

    always #10 clk = ~clk;

    function automatic logic [67:0] model(input logic [3:0] op, input logic w,
            input logic [63:0] a, input logic [63:0] rb, input logic ui,
            input logic [11:0] im, input logic sx, input logic [5:0] sh);
        logic [63:0] b, r;
        logic [31:0] x, y, q;
        logic n, z, c, v;
        int s;
        c = 0; v = 0;
        if (ui) b = {52'd0, im};
        else if (w && sx && op <= 1) b = {{32{rb[31]}}, rb[31:0]};
        else b = rb;
        if (w) begin
            s = sh % 64;
            case (op)
                0: begin r = a + b; c = (r < a); v = (a[63] == b[63]) && (r[63] != a[63]); end
                1: begin r = a - b; c = (a >= b); v = (a[63] != b[63]) && (r[63] != a[63]); end
                2: r = a & b;
                3: r = a | b;
                4: r = a ^ b;
                5: r = a << s;
                6: r = a >> s;
                7: r = $signed(a) >>> s;
                8: r = (s == 0) ? a : ((a >> s) | (a << (64 - s)));
                default: r = 0;
            endcase
            n = r[63]; z = (r == 0);
        end else begin
            s = sh % 32; x = a[31:0]; y = b[31:0];
            case (op)
                0: begin q = x + y; c = (q < x); v = (x[31] == y[31]) && (q[31] != x[31]); end
                1: begin q = x - y; c = (x >= y); v = (x[31] != y[31]) && (q[31] != x[31]); end
                2: q = x & y;
                3: q = x | y;
                4: q = x ^ y;
                5: q = x << s;
                6: q = x >> s;
                7: q = $signed(x) >>> s;
                8: q = (s == 0) ? x : ((x >> s) | (x << (32 - s)));
                default: q = 0;
            endcase
            r = {32'd0, q}; n = q[31]; z = (q == 0);
        end
        return {n, z, c, v, r};
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic w,
                                     input logic ui, input logic sx);
        if (ui) return "R8";
        if (w && sx && op <= 1) return "R7";
        if (op <= 1) return w ? "R1" : "R2";
        if (op <= 4) return "R4";
        if (op <= 7) return "R5";
        return "R6";
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [3:0] op, input logic w, input logic [63:0] a,
            input logic [63:0] b, input logic ui, input logic [11:0] im,
            input logic sx, input logic [5:0] sh, input logic fe);
        logic [67:0] e;
        string t;
        op_i = op; wide_i = w; opa_i = a; opb_i = b; use_imm_i = ui;
        imm_i = im; sext_b_i = sx; shamt_i = sh; flag_en_i = fe;
        e = model(op, w, a, b, ui, im, sx, sh);
        t = tag_of(op, w, ui, sx);
        if (fe) exp_flags = e[67:64];
        @(posedge clk); #1;
        check(t, result_o, e[63:0]);
        check(fe ? t : "R9", {60'd0, flags_o}, {60'd0, exp_flags});
        if (!w) check("R3", {32'd0, result_o[63:32]}, 64'd0);
    endtask

    task automatic do_reset();
        rst = 1;
        @(posedge clk); #1;
        check("R10", result_o, 64'd0);
        check("R10", {60'd0, flags_o}, 64'd0);
        exp_flags = 0;
        rst = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #1;
        do_reset();
        // R1: wide wrap to zero with carry out
        do_op(0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 1);
        // R1: wide subtract with borrow
        do_op(1, 1, 64'd5, 64'd7, 0, 0, 0, 0, 1);
        // R1: signed overflow at bit 63
        do_op(0, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 1);
        // R2: narrow overflow at bit 31, upper operand bits ignored
        do_op(0, 0, 64'hABCD_0000_7FFF_FFFF, 64'h1234_0000_0000_0001, 0, 0, 0, 0, 1);
        // R2: narrow zero despite nonzero upper halves
        do_op(1, 0, 64'hFFFF_FFFF_0000_0010, 64'h0000_0001_0000_0010, 0, 0, 0, 0, 1);
        // R3: bitwise OR in narrow form clears upper half
        do_op(3, 0, 64'hFFFF_0000_0000_0001, 64'h0F0F_0000_0000_0100, 0, 0, 0, 0, 1);
        // R4: XOR to zero with C/V cleared
        do_op(4, 1, 64'hDEAD_BEEF_0000_1111, 64'hDEAD_BEEF_0000_1111, 0, 0, 0, 0, 1);
        // R5: narrow arithmetic shift fills from bit 31, amount 36 -> 4
        do_op(7, 0, 64'h0000_0000_8000_0000, 0, 0, 0, 0, 6'd36, 1);
        // R5: wide logical right by 63
        do_op(6, 1, 64'h8000_0000_0000_0000, 0, 0, 0, 0, 6'd63, 1);
        // R6: rotate of 1 by 1 in each width
        do_op(8, 0, 64'h0000_0001_0000_0001, 0, 0, 0, 0, 6'd1, 1);
        do_op(8, 1, 64'h0000_0000_0000_0001, 0, 0, 0, 0, 6'd1, 1);
        // R7: sign-extended low half of B: 10 + (-1) = 9
        do_op(0, 1, 64'd10, 64'h0000_0000_FFFF_FFFF, 0, 0, 1, 0, 1);
        // R8: immediate overrides B and the extend select
        do_op(1, 1, 64'd100, 64'hFFFF_FFFF_FFFF_FFFF, 1, 12'hFFF, 1, 0, 1);
        // R9: flags hold with enable low
        do_op(0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 1);
        do_op(1, 1, 64'd1, 64'd9, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3000; i++) begin
            do_op(4'($urandom % 9), 1'($urandom), {$urandom, $urandom},
                  ($urandom % 4 == 0) ? {$urandom % 3, $urandom} : {$urandom, $urandom},
                  ($urandom % 5 == 0), 12'($urandom), 1'($urandom),
                  6'($urandom), ($urandom % 4 != 0));
            if (i == 1500) do_reset();
        end
        do_reset();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule